// File: doc/BRIEF.md
# Serial Pattern Generator Channel

This block is a single output lane of a programmable serial pattern source. It holds a seed word of up to 64 bits and sends it one bit at a time on a data output, together with a pattern clock generated from the I/O clock by a programmable ratio. The seed is sent a programmed number of times in a row. When the last bit of the last pass has been sent, a one-cycle done pulse is raised.

Configuration comes in as plain levels: the clock polarity, the prescale ratio, the seed, a length field and a repeat field. The length field holds the number of seed bits minus one. The repeat field holds the number of passes minus one. Every configuration value is captured on the clock edge at which a high enable is first seen. From then on it stays frozen until enable drops. Dropping enable at any point aborts the run and returns both outputs to their idle levels.

The controller has four states:
- `ST_IDLE`: waiting for enable; outputs at idle.
- `ST_RUN`: shifting the seed out.
- `ST_DONE`: the single cycle of the done pulse.
- `ST_HOLD`: finished, waiting for enable to drop.

Its transitions are:
- start: `ST_IDLE` to `ST_RUN`, when enable is high.
- finish: `ST_RUN` to `ST_DONE`, on the final return of the pattern clock to idle.
- settle: `ST_DONE` to `ST_HOLD`, when enable is still high.
- abort: `ST_RUN` to `ST_IDLE`, when enable is low.
- release: `ST_DONE` or `ST_HOLD` to `ST_IDLE`, when enable is low.

Top module: `serial_pattern_channel`

## Requirements
- R1: While reset is applied and after it is released with enable low, `pdata_o` is 0, `done_o` is 0 and `pclk_o` equals `polarity_i`.
- R2: The idle level of `pclk_o` equals the captured polarity bit. The first edge after start moves the clock away from that level. The data output changes only on edges that return the clock to its idle level: the falling edge when the polarity is 0 and the rising edge when it is 1.
- R3: On the edge that samples enable high in `ST_IDLE`, the channel starts. `pclk_o` toggles every `ratio+1` I/O clock cycles, and its first toggle comes `ratio+1` cycles after the start edge.
- R4: The seed is sent least significant bit first, starting at bit 0. Each pass sends `len+1` bits, bits 0 to `len`, one bit per full pattern clock period.
- R5: The pattern is sent `reps+1` times back to back. Each pass starts again at seed bit 0.
- R6: `done_o` is high for exactly one cycle. It rises on the same edge at which `pclk_o` makes its last return to idle, which is `2*(ratio+1)*(len+1)*(reps+1)` cycles after the start edge.
- R7: After the done pulse and while enable stays high, `pclk_o` rests at its idle level and `pdata_o` is 0. No further done pulse appears until enable goes low and then high again.
- R8: On the first edge that samples enable low, the run is aborted: `pdata_o` becomes 0, `pclk_o` follows `polarity_i`, and no done pulse is produced. A later enable starts a fresh run from seed bit 0.
- R9: Changes on `polarity_i`, `ratio_i`, `seed_i`, `len_i` and `reps_i` after the start edge have no effect on the outputs while enable stays high.
- R10: With every configuration value at 0, a start sends one bit (seed bit 0) in one pass. `done_o` rises 2 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; a high level in idle starts, a low level aborts or releases |
| polarity_i | input | 1 | Pattern clock idle level and edge select |
| ratio_i | input | 32 | Prescale ratio; the pattern clock half period is ratio+1 cycles |
| seed_i | input | 64 | Seed pattern, bit 0 sent first |
| len_i | input | 6 | Seed length minus one |
| reps_i | input | 10 | Number of passes minus one |
| pdata_o | output | 1 | Serial pattern data |
| pclk_o | output | 1 | Pattern clock |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths: a 32-bit ratio, a 6-bit length (64-bit seed) and a 10-bit repeat field. It compares the whole output stream cycle by cycle against a model computed from the requirements. The longest seed (64 bits) and the largest repeat count (1024 passes) are tested separately, each paired with a minimal value of the other. This keeps both limits within a few thousand cycles. Small ratios with both polarities cover the edge placement. A mid-run change of every input and a mid-run abort with restart cover the freeze and cancel paths.

// File: rtl/spg_pkg.sv
package spg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_HOLD = 2'd3
    } spg_state_e;

endpackage

// File: rtl/spg_prescaler.sv
module spg_prescaler #(
    parameter int RATIO_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);

    logic [RATIO_W-1:0] cnt_q;
    logic               wrap;

    assign wrap   = (cnt_q == ratio_i);
    assign tick_o = run_i && wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q <= ratio_i));

endmodule

// File: rtl/spg_seq_counter.sv
module spg_seq_counter #(
    parameter int LEN_W  = 6,
    parameter int REPS_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [REPS_W-1:0] reps_i,
    output logic [LEN_W-1:0]  bit_o,
    output logic              last_o
);

    logic [LEN_W-1:0]  bit_q;
    logic [REPS_W-1:0] pass_q;
    logic              pass_end;

    assign pass_end = (bit_q == len_i);
    assign last_o   = pass_end && (pass_q == reps_i);
    assign bit_o    = bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_q  <= '0;
            pass_q <= '0;
        end else if (clr_i) begin
            bit_q  <= '0;
            pass_q <= '0;
        end else if (step_i) begin
            if (pass_end) begin
                bit_q  <= '0;
                pass_q <= pass_q + 1'b1;
            end else begin
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    // R4
    bit_within_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |-> (bit_q <= len_i));

    // R5
    pass_within_reps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |-> (pass_q <= reps_i));

endmodule

// File: rtl/serial_pattern_channel.sv
module serial_pattern_channel
    import spg_pkg::*;
#(
    parameter int RATIO_W = 32,
    parameter int LEN_W   = 6,
    parameter int REPS_W  = 10,
    localparam int SEED_W = 1 << LEN_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               enable_i,
    input  logic               polarity_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [SEED_W-1:0]  seed_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [REPS_W-1:0]  reps_i,
    output logic               pdata_o,
    output logic               pclk_o,
    output logic               done_o
);

    spg_state_e         state_q, state_d;
    logic               pol_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [SEED_W-1:0]  seed_q;
    logic [LEN_W-1:0]   len_q;
    logic [REPS_W-1:0]  reps_q;
    logic               phase_q;
    logic               running;
    logic               tick;
    logic               step;
    logic               last;
    logic [LEN_W-1:0]   bit_idx;

    assign running = (state_q == ST_RUN);
    assign step    = tick && phase_q;

    spg_prescaler #(
        .RATIO_W (RATIO_W)
    ) i_prescaler (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (running),
        .ratio_i (ratio_q),
        .tick_o  (tick)
    );

    spg_seq_counter #(
        .LEN_W  (LEN_W),
        .REPS_W (REPS_W)
    ) i_seq_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (!running),
        .step_i (step),
        .len_i  (len_q),
        .reps_i (reps_q),
        .bit_o  (bit_idx),
        .last_o (last)
    );

    // Next-state logic: start, finish, settle, abort, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i)     state_d = ST_RUN;
            ST_RUN:  if (!enable_i)    state_d = ST_IDLE;
                     else if (step && last) state_d = ST_DONE;
            ST_DONE: state_d = enable_i ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!enable_i)    state_d = ST_IDLE;
        endcase
    end

    // State register, configuration capture and clock phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pol_q   <= 1'b0;
            ratio_q <= '0;
            seed_q  <= '0;
            len_q   <= '0;
            reps_q  <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && enable_i) begin
                pol_q   <= polarity_i;
                ratio_q <= ratio_i;
                seed_q  <= seed_i;
                len_q   <= len_i;
                reps_q  <= reps_i;
            end
            if (!running) begin
                phase_q <= 1'b0;
            end else if (tick) begin
                phase_q <= ~phase_q;
            end
        end
    end

    // Output decode
    always_comb begin
        pdata_o = 1'b0;
        pclk_o  = pol_q;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: pclk_o = polarity_i;
            ST_RUN: begin
                pclk_o  = pol_q ^ phase_q;
                pdata_o = seed_q[bit_idx];
            end
            ST_DONE: done_o = 1'b1;
            ST_HOLD: ;
        endcase
    end

    // R6
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(state_q == ST_RUN));

    // R8
    abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!pdata_o && !done_o));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE && $past(state_q != ST_IDLE)) |->
            ($stable(seed_q) && $stable(ratio_q) && $stable(len_q)
             && $stable(reps_q) && $stable(pol_q)));

    // R2
    data_on_idle_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && $past(running) && !$stable(bit_idx)) |-> (pclk_o == pol_q));

endmodule

// File: tb/test_serial_pattern_channel.sv
module test_serial_pattern_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        polarity = 1'b0;
    logic [31:0] ratio = '0;
    logic [63:0] seed = '0;
    logic [5:0]  len = '0;
    logic [9:0]  reps = '0;
    logic        pdata, pclk, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_pattern_channel i_serial_pattern_channel (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .enable_i   (enable),
        .polarity_i (polarity),
        .ratio_i    (ratio),
        .seed_i     (seed),
        .len_i      (len),
        .reps_i     (reps),
        .pdata_o    (pdata),
        .pclk_o     (pclk),
        .done_o     (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        enable = 1'b0;
        polarity = 1'b1;
        repeat (3) @(negedge clk);
        check(pdata == 1'b0 && done == 1'b0, "R1 pdata/done in reset", {pdata, done}, 0);
        check(pclk == 1'b1, "R1 pclk idle in reset", pclk, 1);
        rst_n = 1'b1;
        @(negedge clk);
        polarity = 1'b0;
        @(negedge clk);
        check(pclk == 1'b0 && pdata == 1'b0 && done == 1'b0, "R1 idle after reset", {pclk, pdata, done}, 0);
    endtask

    // Runs one pattern and compares the whole stream (R2 R3 R4 R5 R6 R7 R9 R10).
    task automatic t_run(input bit pol, input int r, input logic [63:0] sd,
                         input int ln, input int rp, input bit perturb, input string tag);
        int half, bits, total, t, b;
        int bad_clk, bad_dat, bad_done;
        bit e_clk, e_dat, e_done;
        bit a_clk, a_dat, a_done;
        half = r + 1;
        bits = ln + 1;
        total = 2 * half * bits * (rp + 1);
        bad_clk = 0; bad_dat = 0; bad_done = 0;
        @(negedge clk);
        polarity = pol;
        ratio = r;
        seed = sd;
        len = ln[5:0];
        reps = rp[9:0];
        enable = 1'b1;
        for (int s = 0; s <= total + 10; s++) begin
            @(negedge clk);
            if (s < total) begin
                t = s / half;
                b = (t / 2) % bits;
                e_clk = pol ^ t[0];
                e_dat = sd[b];
                e_done = 1'b0;
            end else begin
                e_clk = pol;
                e_dat = 1'b0;
                e_done = (s == total);
            end
            if (pclk !== e_clk) begin
                if (bad_clk == 0) begin a_clk = pclk; $display("  %s pclk mismatch at cycle %0d", tag, s); end
                bad_clk++;
            end
            if (pdata !== e_dat) begin
                if (bad_dat == 0) begin a_dat = pdata; $display("  %s pdata mismatch at cycle %0d", tag, s); end
                bad_dat++;
            end
            if (done !== e_done) begin
                if (bad_done == 0) begin a_done = done; $display("  %s done mismatch at cycle %0d", tag, s); end
                bad_done++;
            end
            if (perturb && s == 0) begin
                // R9: every configuration input changes after the start edge
                polarity = ~pol;
                ratio = r + 5;
                seed = ~sd;
                len = 6'(ln + 3);
                reps = 10'(rp + 2);
            end
        end
        check(bad_clk == 0, {tag, " R2 R3 pclk stream mismatches"}, bad_clk, 0);
        check(bad_dat == 0, {tag, " R4 R5 pdata stream mismatches"}, bad_dat, 0);
        check(bad_done == 0, {tag, " R6 R7 done pulse mismatches"}, bad_done, 0);
        enable = 1'b0;
        polarity = ~pol;
        @(negedge clk);
        check(pclk == ~pol && pdata == 1'b0 && done == 1'b0, {tag, " R7 release to idle"},
              {pclk, pdata, done}, {~pol, 2'b00});
    endtask

    // R8: abort mid-run, then restart from bit 0
    task automatic t_abort();
        int seen_done;
        @(negedge clk);
        polarity = 1'b0;
        ratio = 1;
        seed = 64'h0000_0000_0000_00F1;
        len = 7;
        reps = 2;
        enable = 1'b1;
        repeat (13) @(negedge clk);
        enable = 1'b0;
        polarity = 1'b1;
        @(negedge clk);
        check(pclk == 1'b1, "R8 pclk follows live polarity after abort", pclk, 1);
        check(pdata == 1'b0 && done == 1'b0, "R8 data and done low after abort", {pdata, done}, 0);
        seen_done = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) seen_done++;
        end
        check(seen_done == 0, "R8 no done after abort", seen_done, 0);
        t_run(1'b1, 1, 64'h0000_0000_0000_00F1, 7, 2, 1'b0, "restart R8");
    endtask

    initial begin
        t_reset();
        t_run(1'b0, 0, 64'h0, 0, 0, 1'b0, "zero-config R10");
        t_run(1'b0, 2, 64'hDEAD_BEEF_0F0F_A5C3, 11, 2, 1'b0, "pol0");
        t_run(1'b1, 0, 64'h8123_4567_89AB_CDE6, 63, 0, 1'b1, "full-seed frozen R9");
        t_run(1'b1, 3, 64'h1, 0, 1023, 1'b0, "max-reps R5");
        t_run(1'b0, 0, 64'h0000_0000_0000_0016, 4, 3, 1'b1, "short frozen R9");
        t_abort();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule